// File: doc/BRIEF.md
# Lower-Part OR Approximate Adder

This block adds two unsigned N-bit operands approximately, trading accuracy in the least significant bits for a shorter carry chain and less logic. The operands are split at bit L. Below the split, each result bit is simply the OR of the two operand bits, and no carry moves between these positions. Above the split, an exact adder of width N−L forms the upper sum and the carry-out. The only link between the two halves is one AND gate. It takes the top bit of each operand's lower field and feeds the result to the exact adder as its carry-in.

The block is purely combinational and has no clock or reset. It suits datapaths that tolerate small numeric error, such as filtering or pixel arithmetic. The split point L is a parameter. A larger L gives a shorter exact chain and a higher error rate. L = 0 turns the block into an ordinary exact N-bit adder. A parameter selects the structure of the upper adder: either an operator-level sum that is left to synthesis, or an explicit ripple chain of full-adder cells. Both structures give identical results. Values of L above N−1 are rejected at elaboration.

Top module: `loa_adder`

## Requirements
- R1: For every bit position i below L, sum_o[i] equals a_i[i] OR b_i[i], and that bit does not depend on any other operand bit.
- R2: The field {cout_o, sum_o[N-1:L]} equals a_i[N-1:L] + b_i[N-1:L] + carry-in, computed exactly over N−L+1 bits.
- R3: The carry-in of the upper adder is a_i[L-1] AND b_i[L-1]. No other lower-field bit has any effect on sum_o[N-1:L] or cout_o.
- R4: cout_o is the carry out of the upper exact adder, that is, bit N−L of the R2 sum.
- R5: When the lower fields of the two operands have no set bit in common, {cout_o, sum_o} equals the exact sum a_i + b_i.
- R6: For L > 0, the absolute difference between {cout_o, sum_o} and the exact sum a_i + b_i never exceeds 2^(L-1).
- R7: The ripple-chain structure and the operator-level structure of the upper adder produce identical outputs for every input.
- R8: With L = 0, {cout_o, sum_o} equals a_i + b_i exactly for every input.
- R9: With L = N−1, the upper adder is one bit wide. sum_o[N-1] and cout_o are formed from a_i[N-1], b_i[N-1] and the carry from a_i[N-2] AND b_i[N-2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| sum_o | output | N | Approximate sum: OR-formed lower field, exact upper field |
| cout_o | output | 1 | Carry out of the upper exact adder |

## Verification
The hardest case to reach from the ports is the carry produced by the AND gate travelling through the entire upper field. This happens only when both lower-field top bits are set and the upper fields sum to all ones, for example 0xFF80 plus 0x0080 in the default configuration. Directed vectors build exactly this pattern to force cout_o from the injected carry alone. Companion vectors set every lower bit except the top one, so that any carry leaking out of the lower field would be visible. A pseudo-random sweep then drives four instances together: the default, the ripple variant, L = 0 and L = N−1. Every output is compared with a bench model of the approximation and checked against the error bound.

// File: rtl/loa_pkg.sv
package loa_pkg;

   // Structure used for the exact upper adder
   typedef enum logic {
      UPPER_BEHAV  = 1'b0,   // operator-level sum, structure left to synthesis
      UPPER_RIPPLE = 1'b1    // explicit chain of full-adder cells
   } upper_arch_e;

endpackage

// File: rtl/loa_fa.sv
module loa_fa (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);

   logic prop;
   logic gen;

   assign prop = x_i ^ y_i;
   assign gen  = x_i & y_i;
   assign s_o  = prop ^ c_i;
   assign c_o  = gen | (prop & c_i);

endmodule

// File: rtl/loa_or_bank.sv
module loa_or_bank #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] z_o
);

   // One OR gate per position; no signal crosses between positions
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign z_o[i] = x_i[i] | y_i[i];
   end

endmodule

// File: rtl/loa_upper_add.sv
module loa_upper_add #(
   parameter int unsigned         W    = 8,
   parameter loa_pkg::upper_arch_e ARCH = loa_pkg::UPPER_BEHAV
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] s_o,
   output logic         cout_o
);

   if (W < 1) begin : g_bad_w
      $error("loa_upper_add: W must be at least 1");
   end

   if (ARCH == loa_pkg::UPPER_RIPPLE) begin : g_ripple
      logic [W:0] chain;
      assign chain[0] = cin_i;
      for (genvar i = 0; i < W; i++) begin : g_cell
         loa_fa u_fa (
            .x_i (x_i[i]),
            .y_i (y_i[i]),
            .c_i (chain[i]),
            .s_o (s_o[i]),
            .c_o (chain[i+1])
         );
      end
      assign cout_o = chain[W];
   end else begin : g_behav
      logic [W:0] total;
      assign total  = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
      assign s_o    = total[W-1:0];
      assign cout_o = total[W];
   end

endmodule

// File: rtl/loa_adder.sv
module loa_adder #(
   parameter int unsigned          N          = 16,
   parameter int unsigned          L          = 8,
   parameter loa_pkg::upper_arch_e UPPER_ARCH = loa_pkg::UPPER_BEHAV
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   output logic [N-1:0] sum_o,
   output logic         cout_o
);

   localparam int unsigned H = N - L;   // width of the exact upper field

   if (N < 1) begin : g_bad_n
      $error("loa_adder: N must be at least 1");
   end
   if (L > N - 1) begin : g_bad_l
      $error("loa_adder: L must not exceed N-1");
   end

   logic upper_cin;

   if (L > 0) begin : g_low
      loa_or_bank #(.W(L)) u_or (
         .x_i (a_i[L-1:0]),
         .y_i (b_i[L-1:0]),
         .z_o (sum_o[L-1:0])
      );
      // single carry bridge between the approximate and exact fields
      assign upper_cin = a_i[L-1] & b_i[L-1];
   end else begin : g_no_low
      assign upper_cin = 1'b0;
   end

   loa_upper_add #(.W(H), .ARCH(UPPER_ARCH)) u_upper (
      .x_i    (a_i[N-1:L]),
      .y_i    (b_i[N-1:L]),
      .cin_i  (upper_cin),
      .s_o    (sum_o[N-1:L]),
      .cout_o (cout_o)
   );

endmodule

// File: rtl/loa_adder_chk.sv
module loa_adder_chk #(
   parameter int unsigned N = 16,
   parameter int unsigned L = 8
) (
   input logic [N-1:0] a_i,
   input logic [N-1:0] b_i,
   input logic [N-1:0] sum_i,
   input logic         cout_i
);

   localparam int unsigned H = N - L;

   logic [N:0] approx;
   logic [N:0] exact;

   assign approx = {cout_i, sum_i};
   assign exact  = {1'b0, a_i} + {1'b0, b_i};

   if (L == 0) begin : g_exact
      always_comb begin
         assert_exact_R8: assert (approx == exact)
            else $error("R8: L=0 result differs from exact sum");
      end
   end else begin : g_approx
      localparam logic [N:0] HALF = {{N{1'b0}}, 1'b1} << (L - 1);

      logic [L-1:0] a_lo, b_lo, s_lo;
      logic [H-1:0] a_hi, b_hi;
      logic [H:0]   hi_tot, hi_delta, hi_ref;
      logic         tap;
      logic [N:0]   err;

      assign a_lo     = a_i[L-1:0];
      assign b_lo     = b_i[L-1:0];
      assign s_lo     = sum_i[L-1:0];
      assign a_hi     = a_i[N-1:L];
      assign b_hi     = b_i[N-1:L];
      assign tap      = a_i[L-1] & b_i[L-1];
      assign hi_tot   = {cout_i, sum_i[N-1:L]};
      assign hi_delta = hi_tot - {1'b0, a_hi} - {1'b0, b_hi};
      assign hi_ref   = {1'b0, a_hi} + {1'b0, b_hi} + {{H{1'b0}}, tap};
      assign err      = (approx >= exact) ? (approx - exact) : (exact - approx);

      always_comb begin
         assert_low_or_R1: assert (((s_lo | a_lo) == s_lo) && ((s_lo | b_lo) == s_lo)
                                   && ((s_lo & ~(a_lo | b_lo)) == '0))
            else $error("R1: lower field is not the union of operand bits");
         assert_upper_exact_R2: assert (hi_delta <= (H+1)'(1))
            else $error("R2: upper field off by more than one carry");
         assert_carry_in_R3: assert (hi_delta == {{H{1'b0}}, tap})
            else $error("R3: upper carry-in differs from AND of top lower bits");
         assert_carry_out_R4: assert (cout_i == hi_ref[H])
            else $error("R4: carry-out differs from upper adder carry");
         assert_disjoint_R5: assert (((a_lo & b_lo) != '0) || (approx == exact))
            else $error("R5: disjoint lower fields gave an inexact result");
         assert_err_bound_R6: assert (err <= HALF)
            else $error("R6: error magnitude above bound");
      end
   end

endmodule

bind loa_adder loa_adder_chk #(.N(N), .L(L)) u_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .sum_i  (sum_o),
   .cout_i (cout_o)
);

// File: tb/loa_adder_tb.sv
`timescale 1ns/1ps
module loa_adder_tb;

   localparam int unsigned N = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   logic [N-1:0] a, b;
   logic [N-1:0] s_def, s_rip, s_l0, s_top;
   logic         c_def, c_rip, c_l0, c_top;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   loa_adder #(.N(N), .L(8), .UPPER_ARCH(loa_pkg::UPPER_BEHAV)) u_dut (
      .a_i(a), .b_i(b), .sum_o(s_def), .cout_o(c_def));
   loa_adder #(.N(N), .L(8), .UPPER_ARCH(loa_pkg::UPPER_RIPPLE)) u_dut_rip (
      .a_i(a), .b_i(b), .sum_o(s_rip), .cout_o(c_rip));
   loa_adder #(.N(N), .L(0), .UPPER_ARCH(loa_pkg::UPPER_RIPPLE)) u_dut_l0 (
      .a_i(a), .b_i(b), .sum_o(s_l0), .cout_o(c_l0));
   loa_adder #(.N(N), .L(N-1), .UPPER_ARCH(loa_pkg::UPPER_BEHAV)) u_dut_top (
      .a_i(a), .b_i(b), .sum_o(s_top), .cout_o(c_top));

   // Model of the approximation, built from the requirements
   function automatic logic [N:0] model(input logic [N-1:0] x, input logic [N-1:0] y,
                                        input int l);
      logic [N:0] mask, lo, hi;
      logic       c;
      mask = ({{N{1'b0}}, 1'b1} << l) - 1;
      lo   = {1'b0, x | y} & mask;
      c    = 1'b0;
      if (l > 0) c = x[l-1] & y[l-1];
      hi   = ({1'b0, x} >> l) + ({1'b0, y} >> l) + {{N{1'b0}}, c};
      return (hi << l) | lo;
   endfunction

   task automatic check(input string req, input logic [N:0] got, input logic [N:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, a, b, got, exp);
      end
   endtask

   task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
      @(negedge clk);
      a = x;
      b = y;
      #1;
   endtask

   task automatic test_idle();
      apply('0, '0);
      check("R1 zero inputs", {c_def, s_def}, '0);
   endtask

   task automatic test_low_or();
      apply(16'h00A5, 16'h005A);
      check("R1 disjoint lower bits", {c_def, s_def}, 17'h000FF);
      apply(16'h007F, 16'h007F);   // no carry leaves the lower field
      check("R1 no internal carry", {c_def, s_def}, 17'h0007F);
      apply(16'h3C33, 16'h1255);
      check("R1 mixed lower bits", {c_def, s_def}, model(a, b, 8));
   endtask

   task automatic test_carry_in();
      apply(16'h0080, 16'h0080);
      check("R3 carry from top lower bits", {c_def, s_def}, 17'h00180);
      apply(16'h0040, 16'h0040);
      check("R3 lower bit below top ignored", {c_def, s_def}, 17'h00040);
      apply(16'h12FF, 16'h347F);
      check("R2 upper exact without carry", {c_def, s_def}, 17'h046FF);
   endtask

   task automatic test_carry_out();
      apply(16'hFF80, 16'h0080);
      check("R4 carry-out from injected carry", {c_def, s_def}, 17'h10080);
      apply(16'hFFFF, 16'hFFFF);
      check("R4 all ones", {c_def, s_def}, 17'h1FFFF);
      apply(16'h8000, 16'h8000);
      check("R4 upper overflow", {c_def, s_def}, 17'h10000);
   endtask

   task automatic test_disjoint();
      apply(16'hABC3, 16'h123C);
      check("R5 disjoint exact", {c_def, s_def}, {1'b0, a} + {1'b0, b});
   endtask

   task automatic test_boundaries();
      apply(16'hFFFF, 16'h0001);
      check("R8 L0 full carry", {c_l0, s_l0}, 17'h10000);
      apply(16'h4000, 16'h4000);
      check("R9 top split carry", {c_top, s_top}, 17'h0C000);
      apply(16'hC000, 16'hC000);
      check("R9 top split overflow", {c_top, s_top}, 17'h1C000);
      apply(16'h3FFF, 16'h3FFF);
      check("R9 no carry below tap", {c_top, s_top}, 17'h03FFF);
   endtask

   task automatic test_sweep();
      logic [31:0] st = 32'h1234_5678;
      logic [N:0]  ex, ap, e;
      for (int i = 0; i < 600; i++) begin
         st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
         apply(st[15:0], st[31:16]);
         check("R2 sweep default", {c_def, s_def}, model(a, b, 8));
         check("R7 ripple matches", {c_rip, s_rip}, {c_def, s_def});
         check("R8 sweep L0", {c_l0, s_l0}, {1'b0, a} + {1'b0, b});
         check("R9 sweep top split", {c_top, s_top}, model(a, b, N-1));
         ex = {1'b0, a} + {1'b0, b};
         ap = {c_def, s_def};
         e  = (ap >= ex) ? ap - ex : ex - ap;
         check("R6 error bound", {16'h0, e <= 17'd128}, 17'd1);
      end
   endtask

   initial begin
      a = '0;
      b = '0;
      test_idle();
      test_low_or();
      test_carry_in();
      test_carry_out();
      test_disjoint();
      test_boundaries();
      test_sweep();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule